// File: doc/BRIEF.md
# Serial I/O Expander Shift Engine

This block drives a chain of external shift registers over four wires (serial clock, data out, data in, load strobe). It can serve up to 32 ports with 1 to 4 bits each. Each frame, the engine shifts one bit for every bit slot of every enabled port. It samples the returning data line in the same slot. A load strobe then tells the external registers to latch their outputs and capture fresh inputs. Sampled values become visible to the host only when a frame has finished completely.

The host uses a plain single-cycle register port. Writes take effect at the clock edge. Reads are combinational from the address. Through this port the host sets the bits per port, the port-enable mask and the serial clock divider, fills the per-port output words, and starts single frames or selects continuous repetition. Software maps a linear pin number n to port n / bits and bit n mod bits. The output value of that pin is the low bit of its 3-bit field in the port word. Its input value is bit `port` of input word `bit`.

Top module: `serial_io_expander`

## Requirements
- R1: After reset, every readable register reads zero, and `sio_clk`, `sio_dout` and `sio_load` are low.
- R2: Register map. Addresses 0..3 read input words 0..3 and are read-only. Address 4 is control: [1:0] bits per port minus one, [2] auto-repeat, [3] start pulse (write-only, reads 0). Address 5 is the divider in [11:0]. Address 6 is the 32-bit port-enable mask, bit p enabling port p. Address 32+p is the output word of port p in [11:0]. Unused bits read zero.
- R3: Each bit slot lasts E = max(divider, 2) system cycles. `sio_clk` is low for the first floor(E/2) cycles of the slot and high for the rest. It stays low outside bit slots.
- R4: A frame visits the enabled ports in ascending order and skips disabled ports. Within each port it visits bits 0 up to the configured count minus one, in ascending order.
- R5: During the slot of port p, bit b, `sio_dout` equals bit 3*b of the output word of port p, read live.
- R6: After the last bit slot, `sio_load` is high for exactly E cycles and `sio_clk` stays low during that time.
- R7: `sio_din` is sampled in the last cycle of each bit slot. All input words are replaced at the end of the load pulse. Bit p of word b holds the value from port p, bit b. Positions that were not shifted in that frame read 0. A read in the cycle of the update returns the old value.
- R8: Writing control with bit 3 set starts one frame, two cycles later, when the engine is idle. With auto-repeat set, frames follow each other back to back with no start pulse. The engine also starts from idle when auto-repeat is set.
- R9: A frame with an empty enable mask has no bit slots. It consists only of the load pulse, and it clears all input words.
- R10: The bit count, enable mask and divider are captured at frame start. Changing them mid-frame affects only the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| sio_din | input | 1 | Serial data returned by the external chain |
| sio_clk | output | 1 | Serial shift clock |
| sio_dout | output | 1 | Serial data to the external chain |
| sio_load | output | 1 | Latch/capture strobe, one slot long |

## Verification
Two events can land in the same cycle. The first is the end-of-frame update of the input words, which falls in the same cycle as a host read of those words. The second is the automatic restart of the next frame, which also falls in that cycle. The bench keeps auto-repeat running with short frames while it reads the input words every cycle. A behavioural model decides, cycle by cycle, whether the old or the new word must appear and whether the shadow capture restarts cleanly. A second overlap is a host write to the enable mask or bit count during a frame. The model checks that it changes only the following frame.

// File: rtl/sie_pkg.sv
package sie_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LOAD  = 2'd2
  } eng_st_t;

  localparam int unsigned ADDR_W = 6;
  localparam logic [ADDR_W-1:0] A_CTRL = 6'h04;
  localparam logic [ADDR_W-1:0] A_DIV  = 6'h05;
  localparam logic [ADDR_W-1:0] A_ENA  = 6'h06;
  localparam int unsigned SRC_W = 3;
endpackage

// File: rtl/sie_regs.sv
module sie_regs
  import sie_pkg::*;
#(
  parameter int unsigned NP    = 32,
  parameter int unsigned MB    = 4,
  parameter int unsigned DIV_W = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [NP-1:0]                 wdata,
  output logic [$clog2(MB)-1:0]         cfg_nb,
  output logic                          cfg_auto,
  output logic [DIV_W-1:0]              cfg_div,
  output logic [NP-1:0]                 cfg_ena,
  output logic [NP-1:0][MB*SRC_W-1:0]   cfg_src,
  output logic                          kick
);
  localparam int unsigned BIT_W    = $clog2(MB);
  localparam int unsigned PORT_W   = $clog2(NP);
  localparam int unsigned SRC_BITS = MB * SRC_W;

  assign kick = we && (addr == A_CTRL) && wdata[BIT_W+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_nb   <= '0;
      cfg_auto <= 1'b0;
      cfg_div  <= '0;
      cfg_ena  <= '0;
      cfg_src  <= '0;
    end else if (we) begin
      if (addr[ADDR_W-1]) begin
        cfg_src[addr[PORT_W-1:0]] <= wdata[SRC_BITS-1:0];
      end else begin
        case (addr)
          A_CTRL: begin
            cfg_nb   <= wdata[BIT_W-1:0];
            cfg_auto <= wdata[BIT_W];
          end
          A_DIV:  cfg_div <= wdata[DIV_W-1:0];
          A_ENA:  cfg_ena <= wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sie_seq.sv
module sie_seq
  import sie_pkg::*;
#(
  parameter int unsigned NP    = 32,
  parameter int unsigned MB    = 4,
  parameter int unsigned DIV_W = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(MB)-1:0]         cfg_nb,
  input  logic                          cfg_auto,
  input  logic [DIV_W-1:0]              cfg_div,
  input  logic [NP-1:0]                 cfg_ena,
  input  logic [NP-1:0][MB*SRC_W-1:0]   cfg_src,
  input  logic                          kick,
  input  logic                          sio_din,
  output logic                          sio_clk,
  output logic                          sio_dout,
  output logic                          sio_load,
  output logic                          frame_start,
  output logic                          smp_we,
  output logic [$clog2(MB)-1:0]         smp_bit,
  output logic [$clog2(NP)-1:0]         smp_port,
  output logic                          smp_val,
  output logic                          commit
);
  localparam int unsigned BIT_W    = $clog2(MB);
  localparam int unsigned PORT_W   = $clog2(NP);
  localparam int unsigned SRC_BITS = MB * SRC_W;
  localparam int unsigned SEL_W    = $clog2(SRC_BITS);

  eng_st_t             st_q;
  logic                go_q;
  logic [DIV_W-1:0]    cnt_q, per_q, per_eff;
  logic [BIT_W-1:0]    nb_q, bit_q;
  logic [NP-1:0]       ena_q;
  logic [PORT_W-1:0]   port_q, first_idx, nxt_idx;
  logic                first_hit, nxt_hit, slot_end;
  logic [SRC_BITS-1:0] cur_word;
  logic [SEL_W-1:0]    sel;

  // Lowest enabled port overall, and lowest latched port above the current one.
  always_comb begin
    first_hit = 1'b0;
    first_idx = '0;
    nxt_hit   = 1'b0;
    nxt_idx   = '0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (cfg_ena[i]) begin
        first_hit = 1'b1;
        first_idx = PORT_W'(i);
      end
      if (ena_q[i] && (i > int'(port_q))) begin
        nxt_hit = 1'b1;
        nxt_idx = PORT_W'(i);
      end
    end
  end

  assign per_eff     = (cfg_div < DIV_W'(2)) ? DIV_W'(2) : cfg_div;
  assign slot_end    = (cnt_q == per_q - DIV_W'(1));
  assign frame_start = ((st_q == ST_IDLE) && (go_q || cfg_auto)) ||
                       ((st_q == ST_LOAD) && slot_end && cfg_auto);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      go_q   <= 1'b0;
      cnt_q  <= '0;
      per_q  <= DIV_W'(2);
      nb_q   <= '0;
      bit_q  <= '0;
      ena_q  <= '0;
      port_q <= '0;
    end else begin
      go_q <= kick || (go_q && !frame_start);
      if (frame_start) begin
        per_q  <= per_eff;
        nb_q   <= cfg_nb;
        ena_q  <= cfg_ena;
        cnt_q  <= '0;
        bit_q  <= '0;
        port_q <= first_idx;
        st_q   <= first_hit ? ST_SHIFT : ST_LOAD;
      end else begin
        case (st_q)
          ST_SHIFT: begin
            if (slot_end) begin
              cnt_q <= '0;
              if (bit_q != nb_q) begin
                bit_q <= bit_q + BIT_W'(1);
              end else begin
                bit_q <= '0;
                if (nxt_hit) port_q <= nxt_idx;
                else         st_q   <= ST_LOAD;
              end
            end else begin
              cnt_q <= cnt_q + DIV_W'(1);
            end
          end
          ST_LOAD: begin
            if (slot_end) begin
              cnt_q <= '0;
              st_q  <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + DIV_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign cur_word = cfg_src[port_q];
  assign sel      = SEL_W'(SRC_W) * SEL_W'(bit_q);
  assign sio_clk  = (st_q == ST_SHIFT) && (cnt_q >= (per_q >> 1));
  assign sio_dout = (st_q == ST_SHIFT) && cur_word[sel];
  assign sio_load = (st_q == ST_LOAD);
  assign smp_we   = (st_q == ST_SHIFT) && slot_end;
  assign smp_bit  = bit_q;
  assign smp_port = port_q;
  assign smp_val  = sio_din;
  assign commit   = (st_q == ST_LOAD) && slot_end;

  a_r4_port_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SHIFT) |-> ena_q[port_q]);
  a_r4_bit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SHIFT) |-> (bit_q <= nb_q));
  a_r3_period_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |-> (per_q >= DIV_W'(2)));
endmodule

// File: rtl/sie_capture.sv
module sie_capture #(
  parameter int unsigned NP = 32,
  parameter int unsigned MB = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_start,
  input  logic                          smp_we,
  input  logic [$clog2(MB)-1:0]         smp_bit,
  input  logic [$clog2(NP)-1:0]         smp_port,
  input  logic                          smp_val,
  input  logic                          commit,
  output logic [MB-1:0][NP-1:0]         in_words
);
  logic [MB-1:0][NP-1:0] shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow   <= '0;
      in_words <= '0;
    end else begin
      if (frame_start)  shadow <= '0;
      else if (smp_we)  shadow[smp_bit][smp_port] <= smp_val;
      if (commit)       in_words <= shadow;
    end
  end

  a_r7_hold_until_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(in_words));
endmodule

// File: rtl/serial_io_expander.sv
module serial_io_expander
  import sie_pkg::*;
#(
  parameter int unsigned NP    = 32,
  parameter int unsigned MB    = 4,
  parameter int unsigned DIV_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              sio_din,
  output logic              sio_clk,
  output logic              sio_dout,
  output logic              sio_load
);
  localparam int unsigned BIT_W    = $clog2(MB);
  localparam int unsigned PORT_W   = $clog2(NP);
  localparam int unsigned SRC_BITS = MB * SRC_W;

  logic [BIT_W-1:0]              cfg_nb, smp_bit;
  logic                          cfg_auto, kick, frame_start, smp_we, smp_val, commit;
  logic [DIV_W-1:0]              cfg_div;
  logic [NP-1:0]                 cfg_ena;
  logic [NP-1:0][SRC_BITS-1:0]   cfg_src;
  logic [PORT_W-1:0]             smp_port;
  logic [MB-1:0][NP-1:0]         in_words;

  sie_regs #(.NP(NP), .MB(MB), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .cfg_nb(cfg_nb), .cfg_auto(cfg_auto), .cfg_div(cfg_div), .cfg_ena(cfg_ena),
    .cfg_src(cfg_src), .kick(kick)
  );

  sie_seq #(.NP(NP), .MB(MB), .DIV_W(DIV_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_nb(cfg_nb), .cfg_auto(cfg_auto),
    .cfg_div(cfg_div), .cfg_ena(cfg_ena), .cfg_src(cfg_src), .kick(kick),
    .sio_din(sio_din), .sio_clk(sio_clk), .sio_dout(sio_dout), .sio_load(sio_load),
    .frame_start(frame_start), .smp_we(smp_we), .smp_bit(smp_bit),
    .smp_port(smp_port), .smp_val(smp_val), .commit(commit)
  );

  sie_capture #(.NP(NP), .MB(MB)) u_cap (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .smp_we(smp_we),
    .smp_bit(smp_bit), .smp_port(smp_port), .smp_val(smp_val),
    .commit(commit), .in_words(in_words)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[ADDR_W-1]) begin
      reg_rdata[SRC_BITS-1:0] = cfg_src[reg_addr[PORT_W-1:0]];
    end else if (reg_addr < ADDR_W'(MB)) begin
      reg_rdata = in_words[reg_addr[BIT_W-1:0]];
    end else begin
      case (reg_addr)
        A_CTRL:  reg_rdata[BIT_W:0]   = {cfg_auto, cfg_nb};
        A_DIV:   reg_rdata[DIV_W-1:0] = cfg_div;
        A_ENA:   reg_rdata            = cfg_ena;
        default: reg_rdata            = '0;
      endcase
    end
  end

  a_r6_load_without_clock: assert property (@(posedge clk) disable iff (!rst_n)
    sio_load |-> !sio_clk);
endmodule

// File: tb/test_serial_io_expander.sv
module test_serial_io_expander;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sio_din = 1'b0;
  logic        sio_clk, sio_dout, sio_load;

  int n_chk = 0;
  int n_err = 0;
  bit live = 1'b0;

  always #2 clk = ~clk;

  serial_io_expander i_serial_io_expander (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sio_din(sio_din),
    .sio_clk(sio_clk), .sio_dout(sio_dout), .sio_load(sio_load)
  );

  // ---------------- behavioural reference model ----------------
  int        m_st, m_cnt, m_per, m_nb, m_port, m_bit;
  bit [31:0] m_ena_l, m_en;
  bit [11:0] m_src [32];
  bit [11:0] m_div;
  bit [1:0]  m_nbf;
  bit        m_auto, m_go;
  bit [31:0] m_sh [4];
  bit [31:0] m_in [4];

  function automatic int lowest_above(input bit [31:0] m, input int from);
    for (int i = from + 1; i < 32; i++) if (m[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin : model
    bit st_go, send, kk;
    int nx;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_per = 2; m_nb = 0; m_port = 0; m_bit = 0;
      m_ena_l = 0; m_en = 0; m_div = 0; m_nbf = 0; m_auto = 0; m_go = 0;
      for (int i = 0; i < 32; i++) m_src[i] = 0;
      for (int i = 0; i < 4; i++) begin m_sh[i] = 0; m_in[i] = 0; end
    end else begin
      send  = (m_st != 0) && (m_cnt == m_per - 1);
      st_go = (m_st == 0 && (m_go || m_auto)) || (m_st == 2 && send && m_auto);
      kk    = reg_we && reg_addr == 6'd4 && reg_wdata[3];
      if (m_st == 2 && send) for (int i = 0; i < 4; i++) m_in[i] = m_sh[i];
      if (st_go) for (int i = 0; i < 4; i++) m_sh[i] = 0;
      else if (m_st == 1 && send) m_sh[m_bit][m_port] = sio_din;
      if (st_go) begin
        m_per = (m_div < 2) ? 2 : int'(m_div);
        m_nb = m_nbf; m_ena_l = m_en; m_cnt = 0; m_bit = 0;
        m_port = lowest_above(m_en, -1);
        m_st = (m_en != 0) ? 1 : 2;
        if (m_port < 0) m_port = 0;
      end else if (m_st == 1) begin
        if (send) begin
          m_cnt = 0;
          if (m_bit < m_nb) m_bit++;
          else begin
            m_bit = 0;
            nx = lowest_above(m_ena_l, m_port);
            if (nx < 0) m_st = 2; else m_port = nx;
          end
        end else m_cnt++;
      end else if (m_st == 2) begin
        if (send) begin m_cnt = 0; m_st = 0; end else m_cnt++;
      end
      m_go = kk ? 1'b1 : (st_go ? 1'b0 : m_go);
      if (reg_we) begin
        if (reg_addr[5]) m_src[reg_addr[4:0]] = reg_wdata[11:0];
        else if (reg_addr == 6'd4) begin m_nbf = reg_wdata[1:0]; m_auto = reg_wdata[2]; end
        else if (reg_addr == 6'd5) m_div = reg_wdata[11:0];
        else if (reg_addr == 6'd6) m_en = reg_wdata;
      end
    end
  end

  function automatic bit [31:0] exp_rd(input bit [5:0] a);
    if (a[5]) return {20'd0, m_src[a[4:0]]};
    if (a < 6'd4) return m_in[a[1:0]];
    case (a)
      6'd4: return {29'd0, m_auto, m_nbf};
      6'd5: return {20'd0, m_div};
      6'd6: return m_en;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- per-cycle comparison and monitors ----------------
  bit dout_q [$];
  int clk_hi, ld_hi, ld_rise;
  bit prev_clk, prev_ld;

  always @(negedge clk) begin
    if (live) begin
      chk("R3 sio_clk", sio_clk, (m_st == 1 && m_cnt >= m_per / 2));
      chk("R5 sio_dout", sio_dout, (m_st == 1) ? m_src[m_port][3*m_bit] : 1'b0);
      chk("R6 sio_load", sio_load, (m_st == 2));
      chk("R7 reg_rdata", reg_rdata, exp_rd(reg_addr));
      if (sio_clk) clk_hi++;
      if (sio_load) ld_hi++;
      if (sio_load && !prev_ld) ld_rise++;
      if (sio_clk && !prev_clk) dout_q.push_back(sio_dout);
    end
    prev_clk = sio_clk;
    prev_ld  = sio_load;
  end

  always @(posedge clk) begin : din_gen
    bit [15:0] lfsr;
    if (lfsr == 0) lfsr = 16'hACE1;
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    sio_din = lfsr[0];
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input bit [5:0] a, input bit [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input bit [5:0] a, input bit [31:0] exp);
    reg_addr = a;
    @(negedge clk);
    chk(req, reg_rdata, exp);
    tick(1);
  endtask

  task automatic clear_mon();
    dout_q.delete();
    clk_hi = 0; ld_hi = 0; ld_rise = 0;
  endtask

  task automatic wait_idle();
    int g = 0;
    tick(3);
    while (m_st != 0 && g < 20000) begin tick(1); g++; end
  endtask

  task automatic check_stream(input string req);
    int k = 0;
    bit exp_bits [$];
    for (int p = 0; p < 32; p++)
      if (m_ena_l[p]) for (int b = 0; b <= m_nb; b++) exp_bits.push_back(m_src[p][3*b]);
    chk({req, " bit count"}, dout_q.size(), exp_bits.size());
    foreach (exp_bits[i]) if (i < dout_q.size()) begin
      chk({req, " bit value"}, dout_q[i], exp_bits[i]);
      k++;
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    live = 1'b1;

    // R1: reset values
    chk("R1 sio_clk", sio_clk, 0);
    chk("R1 sio_load", sio_load, 0);
    chk("R1 sio_dout", sio_dout, 0);
    rd_chk("R1 input word", 6'd0, 0);
    rd_chk("R1 ctrl", 6'd4, 0);
    rd_chk("R1 div", 6'd5, 0);
    rd_chk("R1 enable", 6'd6, 0);
    rd_chk("R1 port word", 6'd63, 0);

    // R2: register access
    wr(6'd4, 32'h1);
    wr(6'd5, 32'd3);
    wr(6'd6, 32'h8000_0005);
    wr(6'd32, 32'hFFFF_F009);
    wr(6'd34, 32'h008);
    wr(6'd63, 32'h001);
    rd_chk("R2 ctrl", 6'd4, 32'h1);
    rd_chk("R2 div", 6'd5, 32'd3);
    rd_chk("R2 enable", 6'd6, 32'h8000_0005);
    rd_chk("R2 port word", 6'd32, 32'h009);
    wr(6'd1, 32'hFFFF_FFFF);
    rd_chk("R2 input read-only", 6'd1, 32'h0);

    // R4 R5 R3 R6 R7: one frame, E = 3, two bits on ports 0, 2, 31
    clear_mon();
    wr(6'd4, 32'h9);
    wait_idle();
    check_stream("R4 R5");
    chk("R3 clk high cycles", clk_hi, 6 * 2);
    chk("R6 load cycles", ld_hi, 3);
    reg_addr = 6'd2; @(negedge clk);
    chk("R7 unshifted word", reg_rdata, 0);
    tick(1);
    reg_addr = 6'd0; @(negedge clk);
    chk("R7 disabled ports zero", reg_rdata & ~32'h8000_0005, 0);
    tick(1);

    // R10: settings latched at frame start (divider 1 -> E = 2)
    wr(6'd5, 32'd1);
    clear_mon();
    wr(6'd4, 32'h9);
    tick(3);
    wr(6'd4, 32'h3);
    wr(6'd6, 32'hFFFF_FFFF);
    wr(6'd5, 32'd7);
    wait_idle();
    chk("R10 latched bit count", dout_q.size(), 6);
    chk("R3 minimum period", clk_hi, 6);

    // R9: empty enable mask
    wr(6'd6, 32'h0);
    wr(6'd5, 32'd4);
    clear_mon();
    wr(6'd4, 32'h8);
    wait_idle();
    chk("R9 no clock", clk_hi, 0);
    chk("R9 load length", ld_hi, 4);
    rd_chk("R9 inputs cleared", 6'd0, 0);

    // R8: auto-repeat, with input reads overlapping the end-of-frame update
    wr(6'd6, 32'h0000_0003);
    wr(6'd5, 32'd2);
    clear_mon();
    reg_addr = 6'd0;
    wr(6'd4, 32'h4);
    reg_addr = 6'd0;
    tick(120);
    chk("R8 repeated frames", (ld_rise >= 10), 1);
    wr(6'd33, 32'h001);
    wr(6'd5, 32'd5);
    reg_addr = 6'd1;
    tick(80);
    wr(6'd4, 32'h0);
    wait_idle();
    clear_mon();
    tick(50);
    chk("R8 stops without repeat", ld_rise, 0);

    live = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule